// File: doc/BRIEF.md
# Microcoded Transfer-Register Datapath

This block holds the hidden transfer registers of a small accumulator machine: a memory address register, a memory data buffer, a program counter, an opcode register and an operand register for the ALU. It has no sequencer of its own. Each cycle an outside microsequencer presents one wide horizontal control word, and every register transfer is enabled by one fixed bit of that word. All transfers enabled in one word happen together on the next rising clock edge.

An instruction word is 16 bits: the opcode in the high byte and an operand address in the low byte. The block drives a single-port 256-word by 16-bit memory. It presents the address and write data from its own registers, raises a read strobe and a write strobe from the control word, and takes the read data back. The accumulator value arrives as an input so it can be stored. The opcode, the data buffer and the operand register are exposed for the sequencer and the ALU.

Top module: `cpu_xfer_datapath`

## Requirements
- R1: A synchronous active-high reset clears the address register, data buffer, operand register, opcode register and program counter to zero. With an all-zero control word, both memory strobes are low.
- R2: Control bit 3 raises `mem_rd` in the same cycle. At the edge it loads the data buffer with `mem_rdata`, which is read from the address in `mem_addr`.
- R3: Control bit 11 raises `mem_wr` in the same cycle. While it is set, `mem_wdata` equals the data buffer and `mem_addr` equals the address register.
- R4: Control bit 4 loads the opcode register from data buffer bits 15..8. The data buffer is not changed.
- R5: Control bit 5 loads the address register from data buffer bits 7..0. Control bit 10 loads it from the program counter. If both bits are set, bit 5 wins.
- R6: Control bit 6 increments the program counter by one, and 255 wraps to 0.
- R7: Control bit 14 loads the program counter from data buffer bits 7..0 and wins over an increment. Control bit 15 clears the program counter and wins over both.
- R8: Control bit 12 loads the data buffer from `acc_in`. Control bit 7 copies the data buffer into the operand register. If bits 3 and 12 are both set, the memory read wins.
- R9: Every register loaded at an edge captures the value its source held before that edge. This holds even when the source is loaded at the same edge.
- R10: Control bits 0, 1, 2, 8, 9, 13 and 16 to 31 have no effect on any register or strobe.
- R11: With no transfer bit set, every register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl | input | 32 | Horizontal control word for this cycle |
| acc_in | input | 16 | Accumulator value to be stored |
| mem_rdata | input | 16 | Memory read data |
| mem_addr | output | 8 | Memory address (address register) |
| mem_wdata | output | 16 | Memory write data (data buffer) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| opcode_out | output | 8 | Opcode register |
| mbr_out | output | 16 | Data buffer register |
| br_out | output | 16 | Operand register for the ALU |

## Verification
The bench builds the block with its default widths: an 8-bit address, 16-bit data and a 32-bit control word. These match a 256-word memory that the bench models itself. With an 8-bit program counter, the wrap from 255 to 0 can be reached in a few cycles by loading 255 and incrementing once. Every priority between conflicting transfer bits, and every case where a register's source is loaded at the same edge, is driven directly on the control word.

// File: rtl/cpu_xfer_pkg.sv
package cpu_xfer_pkg;

  // Fixed control-word bit positions; the microprogram depends on them.
  localparam int unsigned BIT_MEM_RD   = 3;
  localparam int unsigned BIT_IR_LD    = 4;
  localparam int unsigned BIT_MAR_MBR  = 5;
  localparam int unsigned BIT_PC_INC   = 6;
  localparam int unsigned BIT_BR_LD    = 7;
  localparam int unsigned BIT_MAR_PC   = 10;
  localparam int unsigned BIT_MEM_WR   = 11;
  localparam int unsigned BIT_MBR_ACC  = 12;
  localparam int unsigned BIT_PC_MBR   = 14;
  localparam int unsigned BIT_PC_CLR   = 15;

  localparam int unsigned NUM_XFER     = 10;

  typedef struct packed {
    logic mem_rd;
    logic ir_ld;
    logic mar_from_mbr;
    logic pc_inc;
    logic br_ld;
    logic mar_from_pc;
    logic mem_wr;
    logic mbr_from_acc;
    logic pc_from_mbr;
    logic pc_clr;
  } xfer_t;

endpackage

// File: rtl/cpu_xfer_decode.sv
module cpu_xfer_decode
  import cpu_xfer_pkg::*;
#(
  parameter int unsigned CTRL_W = 32
) (
  input  logic [CTRL_W-1:0] ctrl,
  output xfer_t             xfer
);

  localparam int unsigned XFER_POS [NUM_XFER] = '{
    BIT_MEM_RD, BIT_IR_LD, BIT_MAR_MBR, BIT_PC_INC, BIT_BR_LD,
    BIT_MAR_PC, BIT_MEM_WR, BIT_MBR_ACC, BIT_PC_MBR, BIT_PC_CLR
  };

  logic [CTRL_W-1:0] used_mask;
  logic [NUM_XFER-1:0] picked;

  // One select per transfer bit; the struct field order matches XFER_POS.
  for (genvar g = 0; g < NUM_XFER; g++) begin : g_pick
    assign picked[NUM_XFER-1-g] = ctrl[XFER_POS[g]];
  end

  always_comb begin
    used_mask = '0;
    for (int i = 0; i < NUM_XFER; i++) begin
      used_mask[XFER_POS[i]] = 1'b1;
    end
  end

  assign xfer = xfer_t'(picked);

  // Bits that no transfer uses are deliberately dropped.
  logic unused_ctrl_bits;
  assign unused_ctrl_bits = ^(ctrl & ~used_mask);

endmodule

// File: rtl/cpu_xfer_addr.sv
module cpu_xfer_addr
  import cpu_xfer_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  xfer_t             xfer,
  input  logic [ADDR_W-1:0] mbr_low,
  output logic [ADDR_W-1:0] mar
);

  logic [ADDR_W-1:0] pc;

  // Program counter: clear beats load, load beats increment.
  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
    end else if (xfer.pc_clr) begin
      pc <= '0;
    end else if (xfer.pc_from_mbr) begin
      pc <= mbr_low;
    end else if (xfer.pc_inc) begin
      pc <= pc + ADDR_W'(1);
    end
  end

  // Address register: operand field beats program counter.
  always_ff @(posedge clk) begin
    if (rst) begin
      mar <= '0;
    end else if (xfer.mar_from_mbr) begin
      mar <= mbr_low;
    end else if (xfer.mar_from_pc) begin
      mar <= pc;
    end
  end

endmodule

// File: rtl/cpu_xfer_data.sv
module cpu_xfer_data
  import cpu_xfer_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned OPC_W = DATA_W - ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  xfer_t             xfer,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] acc_in,
  output logic [DATA_W-1:0] mbr,
  output logic [DATA_W-1:0] br,
  output logic [OPC_W-1:0]  ir
);

  // Data buffer: memory read beats accumulator copy.
  always_ff @(posedge clk) begin
    if (rst) begin
      mbr <= '0;
    end else if (xfer.mem_rd) begin
      mbr <= mem_rdata;
    end else if (xfer.mbr_from_acc) begin
      mbr <= acc_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      br <= '0;
    end else if (xfer.br_ld) begin
      br <= mbr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir <= '0;
    end else if (xfer.ir_ld) begin
      ir <= mbr[DATA_W-1:ADDR_W];
    end
  end

endmodule

// File: rtl/cpu_xfer_datapath.sv
module cpu_xfer_datapath
  import cpu_xfer_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CTRL_W = 32,
  localparam int unsigned OPC_W = DATA_W - ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [OPC_W-1:0]  opcode_out,
  output logic [DATA_W-1:0] mbr_out,
  output logic [DATA_W-1:0] br_out
);

  xfer_t             xfer;
  logic [DATA_W-1:0] mbr_q;

  cpu_xfer_decode #(.CTRL_W(CTRL_W)) u_decode (
    .ctrl (ctrl),
    .xfer (xfer)
  );

  cpu_xfer_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .xfer    (xfer),
    .mbr_low (mbr_q[ADDR_W-1:0]),
    .mar     (mem_addr)
  );

  cpu_xfer_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk       (clk),
    .rst       (rst),
    .xfer      (xfer),
    .mem_rdata (mem_rdata),
    .acc_in    (acc_in),
    .mbr       (mbr_q),
    .br        (br_out),
    .ir        (opcode_out)
  );

  assign mbr_out   = mbr_q;
  assign mem_wdata = mbr_q;
  assign mem_rd    = xfer.mem_rd;
  assign mem_wr    = xfer.mem_wr;

endmodule

// File: rtl/cpu_xfer_datapath_chk.sv
module cpu_xfer_datapath_chk
  import cpu_xfer_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CTRL_W = 32,
  localparam int unsigned OPC_W = DATA_W - ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic [CTRL_W-1:0] ctrl,
  input logic [DATA_W-1:0] acc_in,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [OPC_W-1:0]  opcode_out,
  input logic [DATA_W-1:0] mbr_out,
  input logic [DATA_W-1:0] br_out
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (mbr_out == '0 && br_out == '0 && opcode_out == '0 && mem_addr == '0));

  assert_mem_read_R2: assert property (@(posedge clk) disable iff (rst)
    ctrl[BIT_MEM_RD] |=> mbr_out == $past(mem_rdata));

  assert_write_data_R3: assert property (@(posedge clk) disable iff (rst)
    ctrl[BIT_MEM_WR] |-> (mem_wr && mem_wdata == mbr_out));

  assert_ir_load_R4: assert property (@(posedge clk) disable iff (rst)
    ctrl[BIT_IR_LD] |=> opcode_out == $past(mbr_out[DATA_W-1:ADDR_W]));

  assert_mar_operand_R5: assert property (@(posedge clk) disable iff (rst)
    ctrl[BIT_MAR_MBR] |=> mem_addr == $past(mbr_out[ADDR_W-1:0]));

  assert_br_copy_R8: assert property (@(posedge clk) disable iff (rst)
    ctrl[BIT_BR_LD] |=> br_out == $past(mbr_out));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    ctrl == '0 |=> ($stable(mbr_out) && $stable(br_out) &&
                    $stable(opcode_out) && $stable(mem_addr)));

endmodule

bind cpu_xfer_datapath cpu_xfer_datapath_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W)
) u_chk (.*);

// File: tb/test_cpu_xfer_datapath.sv
module test_cpu_xfer_datapath;

  localparam int CLK_P = 10;

  // Control bit masks, per the requirements.
  localparam logic [31:0] C_RD    = 32'h1 << 3;   // R2
  localparam logic [31:0] C_IR    = 32'h1 << 4;   // R4
  localparam logic [31:0] C_MAROP = 32'h1 << 5;   // R5
  localparam logic [31:0] C_INC   = 32'h1 << 6;   // R6
  localparam logic [31:0] C_BR    = 32'h1 << 7;   // R8
  localparam logic [31:0] C_MARPC = 32'h1 << 10;  // R5
  localparam logic [31:0] C_WR    = 32'h1 << 11;  // R3
  localparam logic [31:0] C_ACC   = 32'h1 << 12;  // R8
  localparam logic [31:0] C_PCLD  = 32'h1 << 14;  // R7
  localparam logic [31:0] C_PCCLR = 32'h1 << 15;  // R7
  localparam logic [31:0] C_UNUSED = 32'hFFFF_2307; // R10

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ctrl = '0;
  logic [15:0] acc_in = '0;
  logic [15:0] mem_rdata;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_rd, mem_wr;
  logic [7:0]  opcode_out;
  logic [15:0] mbr_out, br_out;

  logic [15:0] mem [256];
  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

  cpu_xfer_datapath i_cpu_xfer_datapath (
    .clk(clk), .rst(rst), .ctrl(ctrl), .acc_in(acc_in), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .opcode_out(opcode_out), .mbr_out(mbr_out), .br_out(br_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [31:0] c, input logic [15:0] a = 16'h0);
    @(negedge clk);
    ctrl = c;
    acc_in = a;
    @(posedge clk);
    #1;
    ctrl = '0;
  endtask

  task automatic set_mbr(input logic [15:0] v);
    cyc(C_ACC, v);
  endtask

  task automatic set_mar(input logic [7:0] v);
    set_mbr({8'h00, v});
    cyc(C_MAROP);
  endtask

  task automatic set_pc(input logic [7:0] v);
    set_mbr({8'h00, v});
    cyc(C_PCLD);
  endtask

  task automatic peek_pc(output logic [7:0] v);
    cyc(C_MARPC);
    v = mem_addr;
  endtask

  task automatic t_reset;
    logic [7:0] p;
    chk("R1 addr", 32'(mem_addr), 32'h0);
    chk("R1 mbr", 32'(mbr_out), 32'h0);
    chk("R1 br", 32'(br_out), 32'h0);
    chk("R1 opcode", 32'(opcode_out), 32'h0);
    chk("R1 strobes", {30'h0, mem_rd, mem_wr}, 32'h0);
    set_pc(8'h3C);
    set_mbr(16'hABCD);
    cyc(C_BR | C_IR);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
    chk("R1 re-reset mbr", 32'(mbr_out), 32'h0);
    chk("R1 re-reset br", 32'(br_out), 32'h0);
    chk("R1 re-reset opcode", 32'(opcode_out), 32'h0);
    peek_pc(p);
    chk("R1 re-reset pc", 32'(p), 32'h0);
  endtask

  task automatic t_read;
    mem[8'h42] = 16'hBEEF;
    set_mar(8'h42);
    @(negedge clk);
    ctrl = C_RD;
    #1;
    chk("R2 rd strobe", 32'(mem_rd), 32'h1);
    chk("R2 wr low on read", 32'(mem_wr), 32'h0);
    @(posedge clk); #1; ctrl = '0;
    chk("R2 mbr from memory", 32'(mbr_out), 32'hBEEF);
  endtask

  task automatic t_write;
    set_mar(8'h10);
    set_mbr(16'h1234);
    @(negedge clk);
    ctrl = C_WR;
    #1;
    chk("R3 wr strobe", 32'(mem_wr), 32'h1);
    chk("R3 wdata", 32'(mem_wdata), 32'h1234);
    chk("R3 addr", 32'(mem_addr), 32'h10);
    @(posedge clk); #1; ctrl = '0;
    chk("R3 memory written", 32'(mem[8'h10]), 32'h1234);
  endtask

  task automatic t_ir;
    set_mbr(16'hA5C3);
    cyc(C_IR);
    chk("R4 opcode", 32'(opcode_out), 32'hA5);
    chk("R4 mbr kept", 32'(mbr_out), 32'hA5C3);
  endtask

  task automatic t_mar;
    set_mar(8'h77);
    chk("R5 mar from operand", 32'(mem_addr), 32'h77);
    set_pc(8'h33);
    cyc(C_MARPC);
    chk("R5 mar from pc", 32'(mem_addr), 32'h33);
    set_mbr(16'h0099);
    cyc(C_MAROP | C_MARPC);
    chk("R5 operand wins", 32'(mem_addr), 32'h99);
  endtask

  task automatic t_pc;
    logic [7:0] p;
    cyc(C_PCCLR);
    cyc(C_INC); cyc(C_INC); cyc(C_INC);
    peek_pc(p);
    chk("R6 three increments", 32'(p), 32'h3);
    set_pc(8'hFF);
    cyc(C_INC);
    peek_pc(p);
    chk("R6 wrap to zero", 32'(p), 32'h0);
    set_mbr(16'h0050);
    cyc(C_PCLD | C_INC);
    peek_pc(p);
    chk("R7 load beats inc", 32'(p), 32'h50);
    set_mbr(16'h0061);
    cyc(C_PCCLR | C_PCLD | C_INC);
    peek_pc(p);
    chk("R7 clear wins", 32'(p), 32'h0);
  endtask

  task automatic t_br_acc;
    set_mbr(16'h9999);
    chk("R8 mbr from acc", 32'(mbr_out), 32'h9999);
    cyc(C_BR);
    chk("R8 br copy", 32'(br_out), 32'h9999);
    mem[8'h42] = 16'hBEEF;
    set_mar(8'h42);
    cyc(C_RD | C_ACC, 16'h1111);
    chk("R8 read beats acc", 32'(mbr_out), 32'hBEEF);
  endtask

  task automatic t_concurrent;
    mem[8'h20] = 16'h7E7E;
    set_mar(8'h20);
    set_mbr(16'h2222);
    cyc(C_RD | C_BR);
    chk("R9 br gets old mbr", 32'(br_out), 32'h2222);
    chk("R9 mbr gets memory", 32'(mbr_out), 32'h7E7E);
    cyc(C_IR | C_ACC, 16'h5A00);
    chk("R9 opcode from old mbr", 32'(opcode_out), 32'h7E);
    set_pc(8'h05);
    cyc(C_MARPC | C_INC);
    chk("R9 mar gets old pc", 32'(mem_addr), 32'h05);
    cyc(C_MARPC);
    chk("R9 pc advanced", 32'(mem_addr), 32'h06);
  endtask

  task automatic t_ignored;
    logic [7:0] p;
    set_pc(8'h2D);
    set_mar(8'h44);
    set_mbr(16'hC0DE);
    cyc(C_BR);
    cyc(C_IR);
    @(negedge clk);
    ctrl = C_UNUSED;
    acc_in = 16'hFFFF;
    #1;
    chk("R10 no strobes", {30'h0, mem_rd, mem_wr}, 32'h0);
    @(posedge clk); #1; ctrl = '0;
    chk("R10 mbr", 32'(mbr_out), 32'hC0DE);
    chk("R10 br", 32'(br_out), 32'hC0DE);
    chk("R10 opcode", 32'(opcode_out), 32'hC0);
    chk("R10 addr", 32'(mem_addr), 32'h44);
    cyc(32'h0, 16'h1357);
    cyc(32'h0, 16'h2468);
    chk("R11 mbr held", 32'(mbr_out), 32'hC0DE);
    chk("R11 addr held", 32'(mem_addr), 32'h44);
    peek_pc(p);
    chk("R10 pc unchanged", 32'(p), 32'h2D);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_read();
    t_write();
    t_ir();
    t_mar();
    t_pc();
    t_br_acc();
    t_concurrent();
    t_ignored();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule